// File: doc/BRIEF.md
# Mailbox Command Decoder with Microsecond Timer

This block interprets a command message that sits in a set of mailbox registers and turns it into doorbell set requests. When the message-waiting pulse arrives, it looks at mailbox word 0 and pulls out three 16-bit fields: command code, sequence tag and control flags. A generic acknowledge flag asks for the "message read" doorbell bit, whatever the command is. The timer-control command arms, re-arms or cancels a one-shot countdown. The countdown is measured in microseconds on an external one-cycle tick, and when it runs out it asks for the "timer expired" doorbell bit.

The block owns no doorbell storage. Its output is a 64-bit set-request vector that the doorbell bank ORs into its host-side register, and each bit in it lasts one cycle. The mailbox words are held steady by the bank and work as plain level inputs. The start pulse qualifies them. The block cannot apply back-pressure: it accepts every message in the cycle of its pulse. Commands other than timer control get no action beyond the acknowledge request and a one-cycle unsupported-command pulse.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After reset, `db_set_o` and `unsup_o` are zero and no timer is pending, so ticks alone never request the expiry bit.
- R2: Word 0 holds the command in bits 15:0, the sequence tag in bits 31:16 and the control flags in bits 47:32 (LSB numbering). When flag value 0x0200 is set, `db_set_o` bit 62 (MSB-first bit 1, message read) is high for exactly the one cycle after the pulse, for any command.
- R3: Flag value 0x0100 (response required), the sequence tag and word 0 bits 63:48 have no effect on any output.
- R4: A command other than 0xD401 raises `unsup_o` for the one cycle after the pulse and leaves any pending countdown untouched.
- R5: Command 0xD401 with flag 0x0001 arms the timer with duration D = `mbox_w1_i[DUR_W-1:0]`. The (D+1)-th tick after arming requests `db_set_o` bit 49 (MSB-first bit 14, timer expired) in the cycle after that tick, so D = 0 expires on the first tick.
- R6: Arming while a countdown is pending drops the old deadline and counts from the new duration.
- R7: Command 0xD401 with flag 0x0002 cancels a pending countdown. With both 0x0001 and 0x0002 set, the net result is cancelled.
- R8: The timer is one-shot: after expiry, no further expiry request occurs until it is armed again.
- R9: A tick that coincides with a timer-control message (start or stop) does not count down or expire the timer.
- R10: An acknowledge request and a timer expiry in the same cycle both appear in the same `db_set_o` word.
- R11: Command 0xD401 with neither start nor stop set changes no timer state and does not raise `unsup_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_go_i | input | 1 | One-cycle pulse: a message is waiting in the mailbox |
| mbox_w0_i | input | 64 | Mailbox word 0 (command header) |
| mbox_w1_i | input | 64 | Mailbox word 1 (timer duration in microseconds) |
| us_tick_i | input | 1 | One-cycle pulse per elapsed microsecond |
| db_set_o | output | 64 | Doorbell set requests, one cycle per event |
| unsup_o | output | 1 | One-cycle pulse for an unsupported command |

## Verification
The assertions assume that `msg_go_i` and `us_tick_i` are single-cycle qualifiers and that the mailbox words are stable during the pulse cycle. They make no assumption about how far apart the pulses are, because ticks and messages can arrive in the same cycle. The stimulus changes inputs only on the falling clock edge and holds each pulse for exactly one cycle. It puts a tick in the same cycle as a message only in the cases where that overlap is the behaviour under test (R9, R10).

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 64;
  localparam int FIELD_W = 16;

  localparam logic [FIELD_W-1:0] CMD_TIMER  = 16'hD401;
  localparam logic [FIELD_W-1:0] FLG_START  = 16'h0001;
  localparam logic [FIELD_W-1:0] FLG_STOP   = 16'h0002;
  localparam logic [FIELD_W-1:0] FLG_RESP   = 16'h0100;
  localparam logic [FIELD_W-1:0] FLG_ACK    = 16'h0200;

  // doorbell positions are MSB-first in the bank, converted to LSB index
  localparam int DB_MSGREAD_BIT = WORD_W - 1 - 1;
  localparam int DB_TEXP_BIT    = WORD_W - 1 - 14;

  typedef struct packed {
    logic [FIELD_W-1:0] flags;
    logic [FIELD_W-1:0] seq;
    logic [FIELD_W-1:0] cmd;
  } cmd_hdr_t;
endpackage

// File: rtl/mbx_cmd_split.sv
module mbx_cmd_split
  import mbx_pkg::*;
(
  input  logic [3*FIELD_W-1:0] hdr_bits_i,
  output cmd_hdr_t             hdr_o,
  output logic                 is_timer_o,
  output logic                 ack_o,
  output logic                 start_o,
  output logic                 stop_o
);
  assign hdr_o      = cmd_hdr_t'(hdr_bits_i);
  assign is_timer_o = (hdr_o.cmd == CMD_TIMER);
  assign ack_o      = |(hdr_o.flags & FLG_ACK);
  assign start_o    = |(hdr_o.flags & FLG_START);
  assign stop_o     = |(hdr_o.flags & FLG_STOP);
endmodule

// File: rtl/mbx_us_timer.sv
module mbx_us_timer #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cancel_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             tick_i,
  output logic             fire_o
);
  logic             armed;
  logic [DUR_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign fire_o  = armed && tick_i && at_zero && !load_i && !cancel_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (cancel_i) begin
      armed <= 1'b0;
    end else if (load_i) begin
      armed <= 1'b1;
      cnt   <= dur_i;
    end else if (armed && tick_i) begin
      if (at_zero) armed <= 1'b0;
      else         cnt   <= cnt - 1'b1;
    end
  end

  // R7
  cancel_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !fire_o);
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick_i && !at_zero && !load_i && !cancel_i) |=> (cnt == $past(cnt) - 1'b1));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !cancel_i) |=> (armed && cnt == $past(dur_i)));
endmodule

// File: rtl/mbx_db_req.sv
module mbx_db_req
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req_i,
  input  logic              exp_req_i,
  output logic [WORD_W-1:0] db_set_o
);
  logic [WORD_W-1:0] nxt;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (b == DB_MSGREAD_BIT) begin : g_ack
      assign nxt[b] = ack_req_i;
    end else if (b == DB_TEXP_BIT) begin : g_exp
      assign nxt[b] = exp_req_i;
    end else begin : g_zero
      assign nxt[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) db_set_o <= '0;
    else        db_set_o <= nxt;
  end
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter int DUR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_go_i,
  input  logic [WORD_W-1:0] mbox_w0_i,
  input  logic [WORD_W-1:0] mbox_w1_i,
  input  logic              us_tick_i,
  output logic [WORD_W-1:0] db_set_o,
  output logic              unsup_o
);
  cmd_hdr_t hdr;
  logic     is_timer, ack, start, stop;
  logic     t_load, t_cancel, t_fire;

  mbx_cmd_split u_split (
    .hdr_bits_i (mbox_w0_i[3*FIELD_W-1:0]),
    .hdr_o      (hdr),
    .is_timer_o (is_timer),
    .ack_o      (ack),
    .start_o    (start),
    .stop_o     (stop)
  );

  assign t_load   = msg_go_i && is_timer && start;
  assign t_cancel = msg_go_i && is_timer && stop;

  mbx_us_timer #(.DUR_W(DUR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (t_load),
    .cancel_i (t_cancel),
    .dur_i    (mbox_w1_i[DUR_W-1:0]),
    .tick_i   (us_tick_i),
    .fire_o   (t_fire)
  );

  mbx_db_req u_db (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_req_i (msg_go_i && ack),
    .exp_req_i (t_fire),
    .db_set_o  (db_set_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) unsup_o <= 1'b0;
    else        unsup_o <= msg_go_i && !is_timer;
  end

  logic unused_bits;
  if (DUR_W < WORD_W) begin : g_hi
    assign unused_bits = ^{mbox_w0_i[WORD_W-1:3*FIELD_W], hdr, mbox_w1_i[WORD_W-1:DUR_W]};
  end else begin : g_full
    assign unused_bits = ^{mbox_w0_i[WORD_W-1:3*FIELD_W], hdr};
  end

  // R2
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_set_o[DB_MSGREAD_BIT] |-> $past(msg_go_i && (mbox_w0_i[47:32] & FLG_ACK) != '0));
  // R4
  unsup_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> $past(msg_go_i && mbox_w0_i[15:0] != CMD_TIMER));
  // R5
  exp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_set_o[DB_TEXP_BIT] |-> $past(us_tick_i));
endmodule

// File: tb/sim_mbx_cmd_engine.sv
`timescale 1ns/1ps
module sim_mbx_cmd_engine;
  localparam int  NV    = 8;
  localparam int  ACKB  = 62;
  localparam int  EXPB  = 49;
  localparam logic [63:0] ACKM = 64'd1 << ACKB;
  localparam logic [63:0] EXPM = 64'd1 << EXPB;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, tick = 1'b0;
  logic [63:0] w0 = '0, w1 = '0, db;
  logic unsup;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  mbx_cmd_engine u0 (.clk(clk), .rst_n(rst_n), .msg_go_i(go), .mbox_w0_i(w0),
    .mbox_w1_i(w1), .us_tick_i(tick), .db_set_o(db), .unsup_o(unsup));

  function automatic logic [63:0] mk(input logic [15:0] hi, fl, sq, cm);
    return {hi, fl, sq, cm};
  endfunction

  // decode table: word 0, expected doorbell, expected unsupported
  localparam logic [63:0] TV_W0 [NV] = '{
    {16'h0000, 16'h0200, 16'h1234, 16'hD701},  // R2 R4
    {16'h0000, 16'h0000, 16'h0001, 16'hD101},  // R4
    {16'h0000, 16'h0100, 16'hABCD, 16'hD702},  // R3
    {16'h0000, 16'h0300, 16'h0000, 16'hD401},  // R11 R2
    {16'h0000, 16'h0000, 16'hFFFF, 16'hD401},  // R11
    {16'h0000, 16'h0200, 16'h0000, 16'hD400},  // R2 R4
    {16'h0000, 16'h0002, 16'h0042, 16'hD401},  // R7 idle stop
    {16'hFFFF, 16'h0000, 16'h0000, 16'hD501}   // R3
  };
  localparam logic [63:0] TV_DB [NV] = '{ACKM, 64'd0, 64'd0, ACKM, 64'd0, ACKM, 64'd0, 64'd0};
  localparam logic        TV_UN [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a0, input logic [63:0] a1, input logic tk,
                      output logic [63:0] d, output logic u);
    @(negedge clk); go = 1'b1; w0 = a0; w1 = a1; tick = tk;
    @(negedge clk); d = db; u = unsup; go = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n, input logic fire_last, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk(req, db, (fire_last && k == n - 1) ? EXPM : 64'd0);
    end
  endtask

  localparam logic [15:0] TMR = 16'hD401;

  initial begin
    logic [63:0] d;
    logic u;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", db, 64'd0);
    chk("R1", {63'd0, unsup}, 64'd0);
    ticks(3, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      send(TV_W0[i], 64'd7, 1'b0, d, u);
      chk("R2/R3 table", d, TV_DB[i]);
      chk("R4/R11 table", {63'd0, u}, {63'd0, TV_UN[i]});
    end

    // R5 duration 3 fires on the 4th tick, then R8 one-shot
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd3, 1'b0, d, u);
    chk("R5", d, 64'd0);
    chk("R11", {63'd0, u}, 64'd0);
    ticks(4, 1'b1, "R5");
    ticks(5, 1'b0, "R8");

    // R5 zero duration fires on first tick
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd0, 1'b0, d, u);
    ticks(1, 1'b1, "R5");

    // R6 restart replaces deadline
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd5, 1'b0, d, u);
    ticks(2, 1'b0, "R6");
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd1, 1'b0, d, u);
    ticks(2, 1'b1, "R6");

    // R7 stop, then start+stop
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd2, 1'b0, d, u);
    ticks(1, 1'b0, "R7");
    send(mk(16'h0, 16'h0002, 16'h0, TMR), 64'd0, 1'b0, d, u);
    ticks(6, 1'b0, "R7");
    send(mk(16'h0, 16'h0003, 16'h0, TMR), 64'd0, 1'b0, d, u);
    ticks(4, 1'b0, "R7");

    // R4 unknown command leaves pending countdown alone
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd2, 1'b0, d, u);
    ticks(1, 1'b0, "R4");
    send(mk(16'h0, 16'h0003, 16'h0, 16'hD402), 64'd0, 1'b0, d, u);
    chk("R4", {63'd0, u}, 64'd1);
    ticks(2, 1'b1, "R4");

    // R9 tick coinciding with a restart is not counted
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd2, 1'b0, d, u);
    ticks(1, 1'b0, "R9");
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd0, 1'b1, d, u);
    chk("R9", d, 64'd0);
    ticks(1, 1'b1, "R9");

    // R10 acknowledge and expiry together
    send(mk(16'h0, 16'h0001, 16'h0, TMR), 64'd0, 1'b0, d, u);
    send(mk(16'h0, 16'h0200, 16'h0, 16'hD701), 64'd0, 1'b1, d, u);
    chk("R10", d, ACKM | EXPM);
    chk("R10", {63'd0, u}, 64'd1);
    ticks(2, 1'b0, "R8");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule